// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data buses, called A and B, that meet at a shared boundary. Each direction owns a storage register with its own clock. The A-side register samples the A bus, and the B-side register samples the B bus. An active-low output enable and a direction input pick which bus the block drives, if any. A per-direction select then picks what that bus carries: either the live value from the opposite bus or the content of the register that belongs to that direction.

Each bus appears as three separate vectors: an input, an output and an output-enable. The tri-state pad is built at the level above. Sampling never depends on the output enable or the direction. A rising edge on either storage clock always records what is on the matching bus, even when both buses are isolated. The registers have a synchronous active-low reset to zero, so simulation starts from a known state.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, a rising edge of `clk_ab` clears the A-side register to zero, and a rising edge of `clk_ba` clears the B-side register to zero. Each register is cleared only by an edge of its own clock.
- R2: With `rst_n` high, every rising edge of `clk_ab` stores `a_in` in the A-side register, whatever the values of `oe_n`, `dir` and the select inputs.
- R3: With `rst_n` high, every rising edge of `clk_ba` stores `b_in` in the B-side register, whatever the values of `oe_n`, `dir` and the select inputs.
- R4: When `oe_n` is 1, `a_oe` and `b_oe` are both all zeros.
- R5: When `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is all zeros. When `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is all zeros. Each enable vector is always either all ones or all zeros.
- R6: `a_oe` and `b_oe` are never both non-zero.
- R7: `b_out` equals `a_in` in the same cycle when `sel_ab` is 0, and equals the A-side register when `sel_ab` is 1. Data is never inverted.
- R8: `a_out` equals `b_in` in the same cycle when `sel_ba` is 0, and equals the B-side register when `sel_ba` is 1. Data is never inverted.
- R9: A stored path changes only after a rising edge of its own clock. A change on the bus input with no such edge leaves it unchanged. After the edge it shows the newly stored value.
- R10: When both clocks rise together, both registers capture their buses on that same edge, in any combination of `oe_n` and `dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low register clear |
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | B-bus source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A-bus source: 0 live B, 1 stored B |
| a_in | input | DATA_W | Value sensed on the A bus |
| a_out | output | DATA_W | Value offered to the A bus |
| a_oe | output | DATA_W | Per-bit drive enable for the A bus |
| b_in | input | DATA_W | Value sensed on the B bus |
| b_out | output | DATA_W | Value offered to the B bus |
| b_oe | output | DATA_W | Per-bit drive enable for the B bus |

## Verification
The bench sweeps every 8-bit value through both live paths and both stored paths. A swapped or inverted mux leg, or a stuck data bit, would therefore show up as a wrong output value.

It samples while both buses are isolated and under every combination of enable and direction. A design that gated sampling with `oe_n` or `dir` would then read back a stale value.

It changes a bus input with no clock edge and checks that the stored path holds. A design whose register followed its input, or whose register was clocked by the wrong clock, would fail this check.

It asserts reset on only one clock. This exposes a design that clears both registers at once, or one that never clears at all.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_A    = 2'd1,
      DRV_B    = 2'd2
   } drive_e;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int W      = 8,
   parameter bit RST_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("xcvr_store: W must be at least 1");
   end

   if (RST_EN) begin : g_rst
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_norst
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) q <= d;
   end

endmodule

// File: rtl/xcvr_ctl.sv
module xcvr_ctl
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         oe_n,
   input  logic         dir,
   output drive_e       mode,
   output logic [W-1:0] a_en,
   output logic [W-1:0] b_en
);

   always_comb begin
      if (oe_n)     mode = DRV_NONE;
      else if (dir) mode = DRV_B;
      else          mode = DRV_A;
   end

   assign a_en = {W{mode == DRV_A}};
   assign b_en = {W{mode == DRV_B}};

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
   parameter int W = 8
) (
   input  logic         use_stored,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] y
);

   assign y = use_stored ? stored : live;

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int DATA_W    = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic              rst_n,
   input  logic              clk_ab,
   input  logic              clk_ba,
   input  logic              oe_n,
   input  logic              dir,
   input  logic              sel_ab,
   input  logic              sel_ba,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic [DATA_W-1:0] b_oe
);
   import xcvr_pkg::*;

   localparam int LANE_W = DATA_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("regbus_xcvr: DATA_W must be at least 1");
   end

   logic [LANE_W-1:0] q_a;
   logic [LANE_W-1:0] q_b;
   drive_e            mode;

   xcvr_store #(.W(LANE_W), .RST_EN(HAS_RESET)) u_store_a (
      .clk   (clk_ab),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (q_a)
   );

   xcvr_store #(.W(LANE_W), .RST_EN(HAS_RESET)) u_store_b (
      .clk   (clk_ba),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (q_b)
   );

   xcvr_ctl #(.W(LANE_W)) u_ctl (
      .oe_n  (oe_n),
      .dir   (dir),
      .mode  (mode),
      .a_en  (a_oe),
      .b_en  (b_oe)
   );

   xcvr_route #(.W(LANE_W)) u_route_to_b (
      .use_stored (sel_ab),
      .live       (a_in),
      .stored     (q_a),
      .y          (b_out)
   );

   xcvr_route #(.W(LANE_W)) u_route_to_a (
      .use_stored (sel_ba),
      .live       (b_in),
      .stored     (q_b),
      .y          (a_out)
   );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int W = 8
) (
   input logic         rst_n,
   input logic         clk_ab,
   input logic         clk_ba,
   input logic         oe_n,
   input logic         dir,
   input logic         sel_ab,
   input logic         sel_ba,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b_out,
   input logic [W-1:0] a_oe,
   input logic [W-1:0] b_oe,
   input logic [W-1:0] q_a,
   input logic [W-1:0] q_b
);

   // R1: clear on the register's own clock
   p_clear_a_r1: assert property (@(posedge clk_ab) !rst_n |=> q_a == '0);
   p_clear_b_r1: assert property (@(posedge clk_ba) !rst_n |=> q_b == '0);

   // R2 / R3: sampling is never gated
   p_cap_a_r2: assert property (@(posedge clk_ab) disable iff (!rst_n)
      rst_n |=> q_a == $past(a_in));
   p_cap_b_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
      rst_n |=> q_b == $past(b_in));

   always_comb begin
      if (rst_n) begin
         // R4
         p_iso_r4: assert (!oe_n || (a_oe == '0 && b_oe == '0));
         // R5
         p_dir_b_r5: assert (!((!oe_n) && dir) || (b_oe == '1 && a_oe == '0));
         p_dir_a_r5: assert (!((!oe_n) && !dir) || (a_oe == '1 && b_oe == '0));
         p_uniform_r5: assert ((a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));
         // R6
         p_one_bus_r6: assert (!((|a_oe) && (|b_oe)));
         // R7 / R8
         p_route_b_r7: assert (b_out == (sel_ab ? q_a : a_in));
         p_route_a_r8: assert (a_out == (sel_ba ? q_b : b_in));
      end
   end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(DATA_W)) u_chk (
   .rst_n  (rst_n),
   .clk_ab (clk_ab),
   .clk_ba (clk_ba),
   .oe_n   (oe_n),
   .dir    (dir),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .a_in   (a_in),
   .b_in   (b_in),
   .a_out  (a_out),
   .b_out  (b_out),
   .a_oe   (a_oe),
   .b_oe   (b_oe),
   .q_a    (q_a),
   .q_b    (q_b)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;

   localparam int W = 8;

   logic         sys_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clk_ab = 1'b0;
   logic         clk_ba = 1'b0;
   logic         oe_n = 1'b1;
   logic         dir = 1'b0;
   logic         sel_ab = 1'b0;
   logic         sel_ba = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   regbus_xcvr #(.DATA_W(W)) u_dut (
      .rst_n  (rst_n),
      .clk_ab (clk_ab),
      .clk_ba (clk_ba),
      .oe_n   (oe_n),
      .dir    (dir),
      .sel_ab (sel_ab),
      .sel_ba (sel_ba),
      .a_in   (a_in),
      .a_out  (a_out),
      .a_oe   (a_oe),
      .b_in   (b_in),
      .b_out  (b_out),
      .b_oe   (b_oe)
   );

   always #5 sys_clk = ~sys_clk;

   always @(posedge sys_clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input bit do_ab, input bit do_ba);
      #2;
      clk_ab = do_ab;
      clk_ba = do_ba;
      #5;
      clk_ab = 1'b0;
      clk_ba = 1'b0;
      #3;
   endtask

   initial begin
      // reset both registers
      a_in = 8'hFF; b_in = 8'hFF;
      pulse(1'b1, 1'b1);
      rst_n = 1'b1;
      #1;
      // R1: both registers read zero after reset
      oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1; #1;
      chk("R1 stored A after reset", b_out, 8'h00);
      chk("R1 stored B after reset", a_out, 8'h00);

      // R4, R5, R6: every enable/direction combination
      for (int k = 0; k < 4; k++) begin
         oe_n = k[1]; dir = k[0]; #1;
         chk("R4/R5 a_oe", a_oe, (!k[1] && !k[0]) ? 8'hFF : 8'h00);
         chk("R4/R5 b_oe", b_oe, (!k[1] &&  k[0]) ? 8'hFF : 8'h00);
         chk("R6 single driver", {7'd0, (|a_oe) && (|b_oe)}, 8'h00);
      end

      // R7, R8: live paths, all values, same cycle
      oe_n = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
      for (int v = 0; v < 256; v++) begin
         a_in = v[7:0]; b_in = ~v[7:0]; dir = v[0]; #1;
         chk("R7 live A to B", b_out, v[7:0]);
         chk("R8 live B to A", a_out, ~v[7:0]);
      end

      // R2, R3: sampling while isolated
      oe_n = 1'b1; a_in = 8'h5A; b_in = 8'hC3;
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
      a_in = 8'h00; b_in = 8'h00;
      oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
      chk("R2 capture while isolated", b_out, 8'h5A);
      dir = 1'b0; sel_ba = 1'b1; #1;
      chk("R3 capture while isolated", a_out, 8'hC3);

      // R9: stored path holds without an edge, updates after it
      dir = 1'b1; a_in = 8'h11; b_in = 8'h22; #1;
      chk("R9 A held without edge", b_out, 8'h5A);
      chk("R9 B held without edge", a_out, 8'hC3);
      pulse(1'b1, 1'b0);
      chk("R9 A updated after clk_ab", b_out, 8'h11);
      chk("R9 B untouched by clk_ab", a_out, 8'hC3);

      // R10, R2, R3, R7, R8: simultaneous capture under every control mix
      for (int v = 0; v < 256; v++) begin
         sel_ab = 1'b0; sel_ba = 1'b0;
         oe_n = v[0]; dir = v[1];
         a_in = v[7:0]; b_in = v[7:0] ^ 8'hA5;
         pulse(1'b1, 1'b1);
         a_in = ~v[7:0]; b_in = 8'h00;
         sel_ab = 1'b1; sel_ba = 1'b1; #1;
         chk("R10 stored A on shared edge", b_out, v[7:0]);
         chk("R10 stored B on shared edge", a_out, v[7:0] ^ 8'hA5);
      end

      // R1: reset on one clock clears only that register
      a_in = 8'h3C; b_in = 8'h96;
      pulse(1'b1, 1'b1);
      rst_n = 1'b0;
      pulse(1'b1, 1'b0);
      #1;
      chk("R1 A cleared by clk_ab", b_out, 8'h00);
      chk("R1 B kept without clk_ba", a_out, 8'h96);
      pulse(1'b0, 1'b1);
      chk("R1 B cleared by clk_ba", a_out, 8'h00);
      rst_n = 1'b1;

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule